// File: doc/BRIEF.md
# Clock Output Mode Controller

This block produces the logic-level clock outputs of a multi-output clock generator from a single fast internal clock. Each output clock is a register that toggles, so output edges fall on the fast clock's rising edge. One divider makes the processor-rate clock. Four groups are derived from it:

- a bank of processor-rate clocks;
- a bank of memory clocks that copy the processor clock;
- a bank of bus clocks at half the processor rate, plus one free-running bus copy;
- a bank of reference-rate clocks from a second divider.

A frequency-select input picks one of two processor half-periods. The bus half-period is twice the processor half-period. The reference rate does not depend on that select.

A two-bit operating mode selects one of four behaviours:

- **Normal**: the clocks run from the dividers.
- **Tri-state**: the block flags that no clock pin is driven.
- **Spread**: the clocks run as in normal mode and a flag is passed through.
- **Test**: every clock family is derived from an external test clock at a fixed ratio.

Every output has its own enable. A disabled output is held low. A new enable value is taken only while that output's clock is low, so a pulse is never cut short.

A mode pin gives two pins a second function. When the mode pin is 1, they are two extra memory clocks. When it is 0, they are two active-low stop inputs: one for the processor clocks and one for the gated bus clocks.

Top module: `clkout_top`

## Requirements
- R1: With `freqSel`=1, every processor and memory clock high pulse lasts HALF_FAST (9) fast cycles. With `freqSel`=0, it lasts HALF_SLOW (10) fast cycles.
- R2: Bus clocks, both gated and free-running, have a high pulse of twice the processor half-period. A bus clock rises only in the same cycle as a processor clock rising edge.
- R3: Reference clocks have a high pulse of REF_HALF (42) fast cycles for either value of `freqSel`.
- R4: `modeSel` encoding: 2'b00 normal, 2'b01 tri-state, 2'b10 spread, 2'b11 test. Tri-state drives `clkDrive` and `dualDrive` low. Spread sets `spreadOn` while the clocks keep normal timing. Normal sets `clkDrive`=1 and `spreadOn`=0.
- R5: In test mode, the timings follow `testClk`. Processor and memory clocks toggle on each `testClk` rising edge (divide by 2). Bus clocks divide by 4. Reference clocks follow `testClk` level after a three-cycle delay.
- R6: A cleared enable bit holds its output low. An enable change takes effect only while that output's clock is low. A pulse in progress when its enable clears completes at full width, and re-enabling never starts a partial pulse.
- R7: When `modePin`=1, `dualClk` carries memory clocks, `dualDrive`=1, and `stopPinN` is ignored. When `modePin`=0, `dualDrive`=0, `dualClk` stays low, and `stopPinN` is honoured.
- R8: With `modePin`=0, `stopPinN[0]`=0 stops the processor clocks low while the memory clocks keep running. `stopPinN[1]`=0 stops `busClk` low while `busFreeClk` keeps running.
- R9: A change of `modeSel` restarts all dividers. The processor and bus clocks are low on the next cycle, and their next rising edges coincide.
- R10: During reset, all clocks are low, `clkDrive`=1 and `spreadOn`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast internal clock |
| rstN | input | 1 | asynchronous active-low reset |
| freqSel | input | 1 | processor rate select |
| modeSel | input | 2 | operating mode field |
| modePin | input | 1 | 1: dual pins are clocks; 0: dual pins are stop inputs |
| stopPinN | input | 2 | [0] processor stop, [1] bus stop, both active low |
| testClk | input | 1 | test clock used in test mode |
| cpuEn | input | NCPU | processor clock enables |
| busEn | input | NBUS | gated bus clock enables |
| busFreeEn | input | 1 | free-running bus clock enable |
| sdEn | input | NSD | memory clock enables |
| dualEn | input | 2 | enables of the two dual-function memory clocks |
| refEn | input | NREF | reference clock enables |
| cpuClk | output | NCPU | processor clocks |
| busClk | output | NBUS | gated bus clocks |
| busFreeClk | output | 1 | free-running bus clock |
| sdClk | output | NSD | memory clocks |
| dualClk | output | 2 | dual-function memory clocks |
| refClk | output | NREF | reference clocks |
| clkDrive | output | 1 | 1 when clock pins are driven |
| dualDrive | output | 1 | 1 when the dual pins are driven as clocks |
| spreadOn | output | 1 | spread mode flag |

## Verification
High-pulse widths are measured under both frequency selects and in test mode. This separates divider timing (9, 10, 42 cycles) from test-clock timing (8, 16, 4 cycles).

Enables are cleared at the start of a high pulse and set again during one. This separates gating that waits for a low clock from gating that would truncate a pulse or start one part-way.

The stop pins are driven low under both mode-pin values. This shows they are honoured only in stop-input mode, and that they spare the free-running bus clock and the memory clocks.

A mode change made while the processor and bus clocks are both high shows the divider restart and the realignment of the two clocks.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_TRI    = 2'b01,
    MODE_SPREAD = 2'b10,
    MODE_TEST   = 2'b11
  } mode_e;

  typedef struct packed {
    logic cpuTick;
    logic refTick;
    logic refFollow;
    logic refLevel;
    logic resync;
    logic cpuRun;
    logic busRun;
  } strobe_t;
endpackage

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
  import clkout_pkg::*;
#(
  parameter int HALF_FAST = 9,
  parameter int HALF_SLOW = 10,
  parameter int REF_HALF  = 42
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       freqSel,
  input  logic [1:0] modeSel,
  input  logic       modePin,
  input  logic [1:0] stopPinN,
  input  logic       testClk,
  output strobe_t    st,
  output logic       clkDrive,
  output logic       spreadOn
);
  localparam int MAXH = (REF_HALF > HALF_SLOW) ? ((REF_HALF > HALF_FAST) ? REF_HALF : HALF_FAST)
                                               : ((HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST);
  localparam int CW = $clog2(MAXH + 1);

  mode_e modeQ;
  mode_e modeNext;
  logic [CW-1:0] cpuCnt, refCnt, halfSel;
  logic tS1, tS2, tPrev, testRise, testMode, resync;
  logic [1:0] stopS1, stopS2;

  assign modeNext = mode_e'(modeSel);
  assign resync   = (modeNext != modeQ);
  assign halfSel  = freqSel ? CW'(HALF_FAST) : CW'(HALF_SLOW);
  assign testMode = (modeQ == MODE_TEST);
  assign testRise = tS2 & ~tPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= MODE_NORMAL;
      cpuCnt <= '0;
      refCnt <= '0;
      tS1    <= 1'b0;
      tS2    <= 1'b0;
      tPrev  <= 1'b0;
      stopS1 <= 2'b11;
      stopS2 <= 2'b11;
    end else begin
      modeQ  <= modeNext;
      tS1    <= testClk;
      tS2    <= tS1;
      tPrev  <= tS2;
      stopS1 <= stopPinN;
      stopS2 <= stopS1;
      if (resync || cpuCnt >= halfSel - 1'b1) cpuCnt <= '0;
      else cpuCnt <= cpuCnt + 1'b1;
      if (resync || refCnt == CW'(REF_HALF - 1)) refCnt <= '0;
      else refCnt <= refCnt + 1'b1;
    end
  end

  always_comb begin
    st.resync    = resync;
    st.cpuTick   = !resync && (testMode ? testRise : (cpuCnt >= halfSel - 1'b1));
    st.refTick   = !resync && !testMode && (refCnt == CW'(REF_HALF - 1));
    st.refFollow = !resync && testMode;
    st.refLevel  = tS2;
    st.cpuRun    = modePin | stopS2[0];
    st.busRun    = modePin | stopS2[1];
  end

  assign clkDrive = (modeQ != MODE_TRI);
  assign spreadOn = (modeQ == MODE_SPREAD);

  // R4: a tri-state field held for two cycles leaves the pins undriven
  p_tristate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b01 && $stable(modeSel)) |=> !clkDrive);

  // R9: a mode change always restarts the processor divider
  p_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != $past(modeSel) && $past(rstN)) |-> (cpuCnt == '0 || !st.cpuTick));
endmodule

// File: rtl/clkout_dp.sv
module clkout_dp
  import clkout_pkg::*;
#(
  parameter int NCPU = 5,
  parameter int NBUS = 6,
  parameter int NSD  = 14,
  parameter int NREF = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         st,
  input  logic            modePin,
  input  logic [NCPU-1:0] cpuEn,
  input  logic [NBUS-1:0] busEn,
  input  logic            busFreeEn,
  input  logic [NSD-1:0]  sdEn,
  input  logic [1:0]      dualEn,
  input  logic [NREF-1:0] refEn,
  output logic [NCPU-1:0] cpuClk,
  output logic [NBUS-1:0] busClk,
  output logic            busFreeClk,
  output logic [NSD-1:0]  sdClk,
  output logic [1:0]      dualClk,
  output logic [NREF-1:0] refClk
);
  logic rawCpu, rawBus, rawRef;
  logic [NCPU-1:0] cpuEff;
  logic [NBUS-1:0] busEff;
  logic            busFreeEff;
  logic [NSD-1:0]  sdEff;
  logic [1:0]      dualEff;
  logic [NREF-1:0] refEff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawCpu <= 1'b0;
      rawBus <= 1'b0;
      rawRef <= 1'b0;
    end else if (st.resync) begin
      rawCpu <= 1'b0;
      rawBus <= 1'b0;
      rawRef <= 1'b0;
    end else begin
      if (st.cpuTick) rawCpu <= ~rawCpu;
      if (st.cpuTick && !rawCpu) rawBus <= ~rawBus;
      if (st.refFollow) rawRef <= st.refLevel;
      else if (st.refTick) rawRef <= ~rawRef;
    end
  end

  // enables are sampled only while the family clock is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuEff     <= '0;
      sdEff      <= '0;
      dualEff    <= '0;
      busEff     <= '0;
      busFreeEff <= 1'b0;
      refEff     <= '0;
    end else begin
      if (!rawCpu) begin
        cpuEff  <= cpuEn & {NCPU{st.cpuRun}};
        sdEff   <= sdEn;
        dualEff <= dualEn & {2{modePin}};
      end
      if (!rawBus) begin
        busEff     <= busEn & {NBUS{st.busRun}};
        busFreeEff <= busFreeEn;
      end
      if (!rawRef) refEff <= refEn;
    end
  end

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    assign cpuClk[i] = rawCpu & cpuEff[i];
  end
  assign sdClk      = {NSD{rawCpu}} & sdEff;
  assign dualClk    = {2{rawCpu}} & dualEff;
  assign busClk     = {NBUS{rawBus}} & busEff;
  assign busFreeClk = rawBus & busFreeEff;
  assign refClk     = {NREF{rawRef}} & refEff;

  // R6: an output only rises together with its source clock (no partial pulse)
  p_full_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuClk[0]) |-> $rose(rawCpu));
  // R2: bus clock rises only with a processor rising edge
  p_bus_phase_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawBus) |-> $rose(rawCpu));
  // R9: restart leaves processor and bus clocks low
  p_resync_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.resync |=> (!rawCpu && !rawBus));
endmodule

// File: rtl/clkout_top.sv
module clkout_top
  import clkout_pkg::*;
#(
  parameter int NCPU      = 5,
  parameter int NBUS      = 6,
  parameter int NSD       = 14,
  parameter int NREF      = 4,
  parameter int HALF_FAST = 9,
  parameter int HALF_SLOW = 10,
  parameter int REF_HALF  = 42
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            freqSel,
  input  logic [1:0]      modeSel,
  input  logic            modePin,
  input  logic [1:0]      stopPinN,
  input  logic            testClk,
  input  logic [NCPU-1:0] cpuEn,
  input  logic [NBUS-1:0] busEn,
  input  logic            busFreeEn,
  input  logic [NSD-1:0]  sdEn,
  input  logic [1:0]      dualEn,
  input  logic [NREF-1:0] refEn,
  output logic [NCPU-1:0] cpuClk,
  output logic [NBUS-1:0] busClk,
  output logic            busFreeClk,
  output logic [NSD-1:0]  sdClk,
  output logic [1:0]      dualClk,
  output logic [NREF-1:0] refClk,
  output logic            clkDrive,
  output logic            dualDrive,
  output logic            spreadOn
);
  strobe_t st;

  clkout_ctrl #(.HALF_FAST(HALF_FAST), .HALF_SLOW(HALF_SLOW), .REF_HALF(REF_HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .freqSel(freqSel), .modeSel(modeSel), .modePin(modePin),
    .stopPinN(stopPinN), .testClk(testClk), .st(st), .clkDrive(clkDrive), .spreadOn(spreadOn)
  );

  clkout_dp #(.NCPU(NCPU), .NBUS(NBUS), .NSD(NSD), .NREF(NREF)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .modePin(modePin), .cpuEn(cpuEn), .busEn(busEn),
    .busFreeEn(busFreeEn), .sdEn(sdEn), .dualEn(dualEn), .refEn(refEn), .cpuClk(cpuClk),
    .busClk(busClk), .busFreeClk(busFreeClk), .sdClk(sdClk), .dualClk(dualClk), .refClk(refClk)
  );

  assign dualDrive = clkDrive & modePin;

  // R7: dual pins never driven as clocks in stop-input mode
  p_dual_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !modePin |-> (!dualDrive && dualClk == 2'b00));
endmodule

// File: tb/clkout_top_tb.sv
module clkout_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic freqSel = 1'b1;
  logic [1:0] modeSel = 2'b00;
  logic modePin = 1'b1;
  logic [1:0] stopPinN = 2'b11;
  logic testClk = 1'b0;
  logic [4:0] cpuEn = '1;
  logic [5:0] busEn = '1;
  logic busFreeEn = 1'b1;
  logic [13:0] sdEn = '1;
  logic [1:0] dualEn = '1;
  logic [3:0] refEn = '1;
  logic [4:0] cpuClk;
  logic [5:0] busClk;
  logic busFreeClk;
  logic [13:0] sdClk;
  logic [1:0] dualClk;
  logic [3:0] refClk;
  logic clkDrive, dualDrive, spreadOn;

  always #2 clk = ~clk;

  clkout_top u_dut (
    .clk(clk), .rstN(rstN), .freqSel(freqSel), .modeSel(modeSel), .modePin(modePin),
    .stopPinN(stopPinN), .testClk(testClk), .cpuEn(cpuEn), .busEn(busEn), .busFreeEn(busFreeEn),
    .sdEn(sdEn), .dualEn(dualEn), .refEn(refEn), .cpuClk(cpuClk), .busClk(busClk),
    .busFreeClk(busFreeClk), .sdClk(sdClk), .dualClk(dualClk), .refClk(refClk),
    .clkDrive(clkDrive), .dualDrive(dualDrive), .spreadOn(spreadOn)
  );

  typedef struct {
    string req;
    int    exp;
  } item_t;
  item_t expQ[$];
  int    actQ[$];
  int compared = 0;
  int mismatched = 0;
  logic finished = 1'b0;

  // scoreboard monitor
  always @(negedge clk) begin
    while (actQ.size() > 0 && expQ.size() > 0) begin
      item_t it;
      int a;
      it = expQ.pop_front();
      a = actQ.pop_front();
      compared++;
      if (a != it.exp) begin
        mismatched++;
        $display("FAIL %s actual=%0d expected=%0d", it.req, a, it.exp);
      end
    end
  end

  task automatic expectVal(input string req, input int exp);
    item_t it;
    it.req = req;
    it.exp = exp;
    expQ.push_back(it);
  endtask

  task automatic report(input string req, input int act, input int exp);
    expectVal(req, exp);
    actQ.push_back(act);
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return cpuClk[0];
      1: return busClk[0];
      2: return refClk[0];
      3: return sdClk[0];
      4: return busFreeClk;
      5: return dualClk[0];
      6: return cpuClk[2];
      default: return 1'b0;
    endcase
  endfunction

  task automatic measHigh(input int sel, output int len);
    len = 0;
    do @(negedge clk); while (sig(sel) !== 1'b0);
    do @(negedge clk); while (sig(sel) !== 1'b1);
    while (sig(sel) === 1'b1) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic countRise(input int sel, input int cycles, output int n);
    logic prev;
    n = 0;
    @(negedge clk);
    prev = sig(sel);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sig(sel) === 1'b1 && prev === 1'b0) n++;
      prev = sig(sel);
    end
  endtask

  logic tgen = 1'b0;
  int tcnt = 0;
  always @(negedge clk) begin
    if (tgen) begin
      tcnt++;
      if (tcnt == 4) begin
        tcnt = 0;
        testClk <= ~testClk;
      end
    end
  end

  task automatic finish();
    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    int len, n;
    repeat (3) @(negedge clk);
    // R10 reset state
    report("R10 cpu low in reset", int'(cpuClk), 0);
    report("R10 bus low in reset", int'(busClk), 0);
    report("R10 clkDrive in reset", int'(clkDrive), 1);
    report("R10 spreadOn in reset", int'(spreadOn), 0);
    rstN = 1'b1;

    // R1 fast rate
    measHigh(0, len); report("R1 cpu high fs=1", len, 9);
    measHigh(3, len); report("R1 sdram high fs=1", len, 9);
    // R3 with fs=1
    measHigh(2, len); report("R3 ref high fs=1", len, 42);
    freqSel = 1'b0;
    measHigh(0, len); measHigh(0, len); report("R1 cpu high fs=0", len, 10);
    // R2 bus half rate
    measHigh(1, len); report("R2 bus high fs=0", len, 20);
    measHigh(4, len); report("R2 free bus high fs=0", len, 20);
    measHigh(2, len); report("R3 ref high fs=0", len, 42);

    // R4 tri-state and spread
    modeSel = 2'b01;
    repeat (2) @(negedge clk);
    report("R4 clkDrive tri", int'(clkDrive), 0);
    report("R4 dualDrive tri", int'(dualDrive), 0);
    modeSel = 2'b10;
    repeat (2) @(negedge clk);
    report("R4 spreadOn", int'(spreadOn), 1);
    report("R4 clkDrive spread", int'(clkDrive), 1);
    measHigh(0, len); report("R4 cpu high in spread", len, 10);

    // R9 restart with both clocks high
    do @(negedge clk); while (!(cpuClk[0] === 1'b1 && busClk[0] === 1'b1));
    modeSel = 2'b00;
    @(negedge clk);
    report("R9 cpu low after change", int'(cpuClk[0]), 0);
    report("R9 bus low after change", int'(busClk[0]), 0);
    report("R4 spreadOn off in normal", int'(spreadOn), 0);
    do @(negedge clk); while (cpuClk[0] !== 1'b1);
    report("R9 bus rises with cpu", int'(busClk[0]), 1);

    // R5 test mode
    tgen = 1'b1;
    modeSel = 2'b11;
    measHigh(0, len); measHigh(0, len); report("R5 cpu high test", len, 8);
    measHigh(3, len); report("R5 sdram high test", len, 8);
    measHigh(1, len); report("R5 bus high test", len, 16);
    measHigh(2, len); report("R5 ref high test", len, 4);
    modeSel = 2'b00;
    tgen = 1'b0;
    repeat (30) @(negedge clk);

    // R6 enable gating
    do @(negedge clk); while (cpuClk[0] !== 1'b1);
    sdEn[0] = 1'b0;
    len = 0;
    while (sdClk[0] === 1'b1) begin len++; @(negedge clk); end
    report("R6 pulse completes after disable", len, 10);
    countRise(3, 60, n); report("R6 disabled sdram stays low", n, 0);
    cpuEn[2] = 1'b0;
    repeat (25) @(negedge clk);
    countRise(6, 60, n); report("R6 disabled cpu stays low", n, 0);
    do @(negedge clk); while (cpuClk[0] !== 1'b1);
    cpuEn[2] = 1'b1;
    @(negedge clk);
    report("R6 no partial pulse on enable", int'(cpuClk[2]), 0);
    measHigh(6, len); report("R6 re-enabled pulse full", len, 10);
    sdEn[0] = 1'b1;

    // R7 mode pin 1 ignores stop pins
    stopPinN = 2'b00;
    repeat (5) @(negedge clk);
    countRise(0, 60, n); report("R7 stop ignored with modePin=1", int'(n > 0), 1);
    report("R7 dualDrive modePin=1", int'(dualDrive), 1);
    measHigh(5, len); report("R7 dual clock high", len, 10);
    stopPinN = 2'b11;
    modePin = 1'b0;
    repeat (25) @(negedge clk);
    report("R7 dualDrive modePin=0", int'(dualDrive), 0);
    countRise(5, 60, n); report("R7 dual low modePin=0", n, 0);

    // R8 stop inputs
    stopPinN = 2'b10;
    repeat (30) @(negedge clk);
    countRise(0, 60, n); report("R8 cpu stopped", n, 0);
    countRise(3, 60, n); report("R8 sdram runs while cpu stopped", int'(n > 0), 1);
    stopPinN = 2'b01;
    repeat (50) @(negedge clk);
    countRise(1, 90, n); report("R8 bus stopped", n, 0);
    countRise(4, 90, n); report("R8 free bus runs", int'(n > 0), 1);
    countRise(0, 60, n); report("R8 cpu resumes", int'(n > 0), 1);
    stopPinN = 2'b11;

    finished = 1'b1;
    finish();
  end
endmodule